// File: doc/BRIEF.md
# Core Standby Wake-Up Controller

This block controls the clocks of one processor core while that core waits in standby. The core pulses a wait-for-interrupt (WFI) or a wait-for-event (WFE) request. The controller then drops the core clock enable and the L1 memory clock enable, and raises a standby flag. From that point only the controller's own wake-detection logic keeps running. The controller chooses wake sources according to the kind of wait. A WFI wait ignores the interrupt and abort mask bits. A WFE wait honours those mask bits, and it also wakes on the external event input and on an SEV from any core in the cluster.

A one-bit event register remembers events that arrive while the core is running or sitting in WFI. A WFE request that finds an event already pending is absorbed: the core stays in run and the pending event is consumed. A coherency request from the interconnect during standby turns the L1 memory clock back on until the requester signals completion. The core clock stays off during that service and the standby flag stays high. All three outputs are registers, so each one changes only at a clock edge.

Top module: `core_standby_ctrl`

## Requirements
- R1: While reset is held and after its release, coreClkEn = 1, l1ClkEn = 1 and inStandby = 0.
- R2: In run, a clock edge that samples wfiReq = 1 sets coreClkEn = 0, l1ClkEn = 0 and inStandby = 1 at that edge. When wfiReq and wfeReq are both high, the request is handled as WFI.
- R3: In WFI standby, irq, fiq or asyncAbort wakes the core whatever the values of maskI, maskF and maskA. The clock edge that samples the wake source restores coreClkEn = 1 and l1ClkEn = 1 and clears inStandby.
- R4: In WFE standby, irq wakes the core only when maskI = 0, fiq only when maskF = 0, and asyncAbort only when maskA = 0. A masked source leaves all three outputs unchanged.
- R5: In WFE standby, eventIn = 1 or any bit of sevCluster = 1 wakes the core at the sampling edge.
- R6: In either kind of standby, a debug event wakes the core when dbgReq or dbgHalt is high and both dbgInvasiveEn and dbgPermit are 1. Otherwise the debug inputs have no effect.
- R7: In either kind of standby, maintReq = 1 wakes the core at the sampling edge.
- R8: An event (eventIn or any sevCluster bit) that arrives in run or in WFI standby sets a pending bit. A WFE request made while the pending bit is set, or while an event arrives in the same cycle, leaves the core in run and clears the pending bit. A WFE wake also clears the pending bit.
- R9: In standby with l1ClkEn = 0, a sampled cohReq = 1 without any wake sets l1ClkEn = 1 at that edge. coreClkEn stays 0 and inStandby stays 1. l1ClkEn then returns to 0 at the edge that samples cohDone = 1.
- R10: In WFI standby, eventIn and sevCluster do not wake the core.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock of the wake logic |
| rstN | input | 1 | Active-low reset |
| wfiReq | input | 1 | Core requests WFI standby |
| wfeReq | input | 1 | Core requests WFE standby |
| irq | input | 1 | Normal interrupt |
| fiq | input | 1 | Fast interrupt |
| asyncAbort | input | 1 | Asynchronous abort |
| maskI | input | 1 | Interrupt mask bit for irq |
| maskF | input | 1 | Interrupt mask bit for fiq |
| maskA | input | 1 | Abort mask bit |
| dbgReq | input | 1 | External debug request pin |
| dbgHalt | input | 1 | Halt command received over the debug port |
| dbgInvasiveEn | input | 1 | Invasive debug enabled |
| dbgPermit | input | 1 | Debug event permitted |
| eventIn | input | 1 | External event input |
| sevCluster | input | NCORES | SEV executed by a core of the cluster, one bit per core |
| maintReq | input | 1 | Cache/TLB maintenance broadcast from another core |
| cohReq | input | 1 | Coherency request that needs the L1 memory |
| cohDone | input | 1 | The coherency request has been serviced |
| coreClkEn | output | 1 | Core clock enable |
| l1ClkEn | output | 1 | L1 memory clock enable |
| inStandby | output | 1 | Core is in standby |

## Verification
Every result of this block is due at the first rising edge that samples its stimulus: entry, wake, L1 restore and L1 release all appear on the outputs right after that edge, and an absorbed WFE shows up as outputs that did not change. The bench drives inputs after a falling edge, lets one rising edge pass, and compares all three outputs at the next falling edge. It compares them against a cycle model that it keeps from the requirements and against literal values in the directed cases. An input that must be ignored is held for a full cycle, and the outputs are checked right after it, before anything else is applied.

// File: rtl/stby_pkg.sv
package stby_pkg;

  typedef enum logic [1:0] {
    ST_RUN = 2'd0,
    ST_WFI = 2'd1,
    ST_WFE = 2'd2
  } stbyState_t;

  // strobes from control to datapath, valid for one cycle
  typedef struct packed {
    logic enter;   // go into standby at this edge
    logic wake;    // return to run at this edge
    logic clrEvt;  // consume the pending event
  } ctlStrobe_t;

endpackage

// File: rtl/stby_wake_dp.sv
module stby_wake_dp #(
  parameter int NCORES = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  irq,
  input  logic                  fiq,
  input  logic                  asyncAbort,
  input  logic                  maskI,
  input  logic                  maskF,
  input  logic                  maskA,
  input  logic                  dbgReq,
  input  logic                  dbgHalt,
  input  logic                  dbgInvasiveEn,
  input  logic                  dbgPermit,
  input  logic                  eventIn,
  input  logic [NCORES-1:0]     sevCluster,
  input  logic                  maintReq,
  input  logic                  cohReq,
  input  logic                  cohDone,
  input  stby_pkg::ctlStrobe_t  strb,
  output logic                  wfiWake,
  output logic                  wfeWake,
  output logic                  evtAvail,
  output logic                  coreClkEn,
  output logic                  l1ClkEn,
  output logic                  inStandby
);

  localparam int NSRC = 3;

  logic [NSRC-1:0] rawSrc;
  logic [NSRC-1:0] srcMask;
  logic [NSRC-1:0] openSrc;
  logic            dbgWake;
  logic            evtIn;
  logic            evtLatch;
  logic            l1Next;

  assign rawSrc  = {asyncAbort, fiq, irq};
  assign srcMask = {maskA, maskF, maskI};

  generate
    for (genvar g = 0; g < NSRC; g++) begin : g_mask
      assign openSrc[g] = rawSrc[g] & ~srcMask[g];
    end
  endgenerate

  assign dbgWake  = (dbgReq | dbgHalt) & dbgInvasiveEn & dbgPermit;
  assign evtIn    = eventIn | (|sevCluster);
  assign evtAvail = evtLatch | evtIn;

  assign wfiWake = (|rawSrc) | dbgWake | maintReq;
  assign wfeWake = (|openSrc) | dbgWake | maintReq | evtIn;

  // L1 clock: restored while a coherency request is in service
  always_comb begin
    if (strb.wake)       l1Next = 1'b1;
    else if (strb.enter) l1Next = 1'b0;
    else if (!inStandby) l1Next = 1'b1;
    else if (l1ClkEn)    l1Next = ~cohDone;
    else                 l1Next = cohReq;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      evtLatch  <= 1'b0;
      coreClkEn <= 1'b1;
      l1ClkEn   <= 1'b1;
      inStandby <= 1'b0;
    end else begin
      evtLatch <= strb.clrEvt ? 1'b0 : (evtLatch | evtIn);
      l1ClkEn  <= l1Next;
      if (strb.enter) begin
        coreClkEn <= 1'b0;
        inStandby <= 1'b1;
      end else if (strb.wake) begin
        coreClkEn <= 1'b1;
        inStandby <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/stby_ctrl.sv
module stby_ctrl (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  wfiReq,
  input  logic                  wfeReq,
  input  logic                  wfiWake,
  input  logic                  wfeWake,
  input  logic                  evtAvail,
  output stby_pkg::stbyState_t  curState,
  output stby_pkg::ctlStrobe_t  strb
);
  import stby_pkg::*;

  stbyState_t nxtState;

  always_comb begin
    nxtState = curState;
    strb     = '0;
    case (curState)
      ST_RUN: begin
        if (wfiReq) begin
          strb.enter = 1'b1;
          nxtState   = ST_WFI;
        end else if (wfeReq) begin
          if (evtAvail) begin
            strb.clrEvt = 1'b1;
          end else begin
            strb.enter = 1'b1;
            nxtState   = ST_WFE;
          end
        end
      end
      ST_WFI: begin
        if (wfiWake) begin
          strb.wake = 1'b1;
          nxtState  = ST_RUN;
        end
      end
      ST_WFE: begin
        if (wfeWake) begin
          strb.wake   = 1'b1;
          strb.clrEvt = 1'b1;
          nxtState    = ST_RUN;
        end
      end
      default: nxtState = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) curState <= ST_RUN;
    else       curState <= nxtState;
  end

endmodule

// File: rtl/core_standby_ctrl.sv
module core_standby_ctrl #(
  parameter int NCORES = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wfiReq,
  input  logic              wfeReq,
  input  logic              irq,
  input  logic              fiq,
  input  logic              asyncAbort,
  input  logic              maskI,
  input  logic              maskF,
  input  logic              maskA,
  input  logic              dbgReq,
  input  logic              dbgHalt,
  input  logic              dbgInvasiveEn,
  input  logic              dbgPermit,
  input  logic              eventIn,
  input  logic [NCORES-1:0] sevCluster,
  input  logic              maintReq,
  input  logic              cohReq,
  input  logic              cohDone,
  output logic              coreClkEn,
  output logic              l1ClkEn,
  output logic              inStandby
);
  import stby_pkg::*;

  stbyState_t curState;
  ctlStrobe_t ctlStrb;
  logic       wfiWake;
  logic       wfeWake;
  logic       evtAvail;

  stby_ctrl i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .wfiReq   (wfiReq),
    .wfeReq   (wfeReq),
    .wfiWake  (wfiWake),
    .wfeWake  (wfeWake),
    .evtAvail (evtAvail),
    .curState (curState),
    .strb     (ctlStrb)
  );

  stby_wake_dp #(.NCORES(NCORES)) i_dp (
    .clk           (clk),
    .rstN          (rstN),
    .irq           (irq),
    .fiq           (fiq),
    .asyncAbort    (asyncAbort),
    .maskI         (maskI),
    .maskF         (maskF),
    .maskA         (maskA),
    .dbgReq        (dbgReq),
    .dbgHalt       (dbgHalt),
    .dbgInvasiveEn (dbgInvasiveEn),
    .dbgPermit     (dbgPermit),
    .eventIn       (eventIn),
    .sevCluster    (sevCluster),
    .maintReq      (maintReq),
    .cohReq        (cohReq),
    .cohDone       (cohDone),
    .strb          (ctlStrb),
    .wfiWake       (wfiWake),
    .wfeWake       (wfeWake),
    .evtAvail      (evtAvail),
    .coreClkEn     (coreClkEn),
    .l1ClkEn       (l1ClkEn),
    .inStandby     (inStandby)
  );

endmodule

// File: rtl/stby_chk.sv
module stby_chk (
  input logic                  clk,
  input logic                  rstN,
  input logic                  wfiReq,
  input logic                  irq,
  input logic                  fiq,
  input logic                  asyncAbort,
  input logic                  cohReq,
  input logic                  coreClkEn,
  input logic                  l1ClkEn,
  input logic                  inStandby,
  input stby_pkg::stbyState_t  curState,
  input stby_pkg::ctlStrobe_t  ctlStrb
);
  import stby_pkg::*;

  // R1: outside standby both clocks run
  p_run_clocks_r1: assert property (@(posedge clk) disable iff (!rstN)
    !inStandby |-> (coreClkEn && l1ClkEn));

  // R2: the core clock is never on during standby
  p_core_off_r2: assert property (@(posedge clk) disable iff (!rstN)
    inStandby |-> !coreClkEn);

  // R2: a WFI request in run enters standby at once
  p_wfi_enter_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!inStandby && wfiReq) |=> (inStandby && !coreClkEn && !l1ClkEn));

  // R3: unmasked or masked, these sources end WFI
  p_wfi_wake_r3: assert property (@(posedge clk) disable iff (!rstN)
    (inStandby && curState == ST_WFI && (irq || fiq || asyncAbort))
      |=> (!inStandby && coreClkEn));

  // R8: an absorbed WFE request keeps the core in run
  p_evt_skip_r8: assert property (@(posedge clk) disable iff (!rstN)
    (ctlStrb.clrEvt && !ctlStrb.wake && !inStandby) |=> !inStandby);

  // R9: coherency restores only the L1 clock
  p_coh_l1_r9: assert property (@(posedge clk) disable iff (!rstN)
    (inStandby && !l1ClkEn && cohReq && !ctlStrb.wake && !ctlStrb.enter)
      |=> (l1ClkEn && inStandby && !coreClkEn));

endmodule

bind core_standby_ctrl stby_chk i_chk (
  .clk        (clk),
  .rstN       (rstN),
  .wfiReq     (wfiReq),
  .irq        (irq),
  .fiq        (fiq),
  .asyncAbort (asyncAbort),
  .cohReq     (cohReq),
  .coreClkEn  (coreClkEn),
  .l1ClkEn    (l1ClkEn),
  .inStandby  (inStandby),
  .curState   (curState),
  .ctlStrb    (ctlStrb)
);

// File: tb/test_core_standby_ctrl.sv
`timescale 1ns/1ps
module test_core_standby_ctrl;
  localparam int NC = 4;
  localparam int RND_CYCLES = 3000;

  logic clk = 1'b0;
  logic rstN;
  logic wfiReq, wfeReq, irq, fiq, asyncAbort, maskI, maskF, maskA;
  logic dbgReq, dbgHalt, dbgInvasiveEn, dbgPermit, eventIn, maintReq;
  logic cohReq, cohDone;
  logic [NC-1:0] sevCluster;
  logic coreClkEn, l1ClkEn, inStandby;

  int errors = 0;
  int checks = 0;

  // model state: 0 run, 1 WFI, 2 WFE
  int   mSt    = 0;
  logic mLatch = 1'b0;
  logic mCore  = 1'b1;
  logic mL1    = 1'b1;
  logic mStby  = 1'b0;

  always #5 clk = ~clk;

  core_standby_ctrl #(.NCORES(NC)) i_core_standby_ctrl (
    .clk(clk), .rstN(rstN), .wfiReq(wfiReq), .wfeReq(wfeReq),
    .irq(irq), .fiq(fiq), .asyncAbort(asyncAbort),
    .maskI(maskI), .maskF(maskF), .maskA(maskA),
    .dbgReq(dbgReq), .dbgHalt(dbgHalt), .dbgInvasiveEn(dbgInvasiveEn),
    .dbgPermit(dbgPermit), .eventIn(eventIn), .sevCluster(sevCluster),
    .maintReq(maintReq), .cohReq(cohReq), .cohDone(cohDone),
    .coreClkEn(coreClkEn), .l1ClkEn(l1ClkEn), .inStandby(inStandby)
  );

  function automatic logic wfiWakeExp();
    logic dbg;
    dbg = (dbgReq | dbgHalt) & dbgInvasiveEn & dbgPermit;
    return irq | fiq | asyncAbort | dbg | maintReq;
  endfunction

  function automatic logic wfeWakeExp();
    logic dbg;
    dbg = (dbgReq | dbgHalt) & dbgInvasiveEn & dbgPermit;
    return (irq & ~maskI) | (fiq & ~maskF) | (asyncAbort & ~maskA) | dbg
           | maintReq | eventIn | (|sevCluster);
  endfunction

  task automatic clr();
    wfiReq = 0; wfeReq = 0; irq = 0; fiq = 0; asyncAbort = 0;
    maskI = 0; maskF = 0; maskA = 0; dbgReq = 0; dbgHalt = 0;
    dbgInvasiveEn = 0; dbgPermit = 0; eventIn = 0; maintReq = 0;
    cohReq = 0; cohDone = 0; sevCluster = '0;
  endtask

  task automatic checkOut(input string tag, input logic [2:0] exp);
    checks++;
    if ({coreClkEn, l1ClkEn, inStandby} !== exp) begin
      errors++;
      $display("FAIL %s: {core,l1,stby} actual=%b expected=%b at %0t",
               tag, {coreClkEn, l1ClkEn, inStandby}, exp, $time);
    end
  endtask

  // one clock: advance model with current inputs, then compare at falling edge
  task automatic step(input string tag);
    logic ev;
    ev = eventIn | (|sevCluster);
    case (mSt)
      0: begin
        if (wfiReq) begin
          mSt = 1; mCore = 0; mL1 = 0; mStby = 1; mLatch = mLatch | ev;
        end else if (wfeReq) begin
          if (mLatch | ev) mLatch = 0;
          else begin mSt = 2; mCore = 0; mL1 = 0; mStby = 1; end
        end else mLatch = mLatch | ev;
      end
      1: begin
        mLatch = mLatch | ev;
        if (wfiWakeExp()) begin mSt = 0; mCore = 1; mL1 = 1; mStby = 0; end
        else mL1 = mL1 ? ~cohDone : cohReq;
      end
      default: begin
        if (wfeWakeExp()) begin
          mSt = 0; mCore = 1; mL1 = 1; mStby = 0; mLatch = 0;
        end else mL1 = mL1 ? ~cohDone : cohReq;
      end
    endcase
    @(posedge clk);
    @(negedge clk);
    checkOut(tag, {mCore, mL1, mStby});
  endtask

  initial begin
    #(1_000_000);
    errors++; checks++;
    $display("FAIL watchdog: run did not finish, actual=timeout expected=done");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    clr();
    rstN = 0;
    repeat (3) @(negedge clk);
    checkOut("R1 in reset", 3'b110);
    rstN = 1;
    @(negedge clk);
    checkOut("R1 after reset", 3'b110);

    // R2: both requests, WFI wins
    wfiReq = 1; wfeReq = 1; step("R2");
    checkOut("R2 enter", 3'b001);
    clr();
    // R10: event does not end WFI, latch set
    eventIn = 1; step("R10");
    checkOut("R10 event ignored in WFI", 3'b001);
    clr();
    // R3: masked irq still ends WFI
    maskI = 1; irq = 1; step("R3");
    checkOut("R3 masked irq wakes WFI", 3'b110);
    clr();
    // R8: pending event absorbs WFE, second WFE enters
    wfeReq = 1; step("R8");
    checkOut("R8 WFE absorbed", 3'b110);
    step("R8");
    checkOut("R8 WFE entered", 3'b001);
    clr();
    // R4: masked irq ignored, unmasked wakes
    maskI = 1; irq = 1; step("R4");
    checkOut("R4 masked irq ignored", 3'b001);
    maskI = 0; step("R4");
    checkOut("R4 unmasked irq wakes", 3'b110);
    clr();
    // R5: SEV ends WFE
    wfeReq = 1; step("R5");
    clr();
    sevCluster = 4'b0100; step("R5");
    checkOut("R5 sev wakes WFE", 3'b110);
    clr();
    // R6: debug needs enable and permission
    wfiReq = 1; step("R6");
    clr();
    dbgReq = 1; dbgPermit = 1; step("R6");
    checkOut("R6 debug without enable ignored", 3'b001);
    dbgReq = 0; dbgHalt = 1; dbgInvasiveEn = 1; step("R6");
    checkOut("R6 debug halt wakes", 3'b110);
    clr();
    // R7: maintenance broadcast ends WFE
    wfeReq = 1; step("R7");
    clr();
    maintReq = 1; step("R7");
    checkOut("R7 maintenance wakes WFE", 3'b110);
    clr();
    // R9: coherency restores L1 only
    wfiReq = 1; step("R9");
    clr();
    cohReq = 1; step("R9");
    checkOut("R9 L1 restored", 3'b011);
    cohReq = 0; step("R9");
    checkOut("R9 L1 held until done", 3'b011);
    cohDone = 1; step("R9");
    checkOut("R9 L1 released", 3'b001);
    clr();
    fiq = 1; step("R3");
    checkOut("R3 fiq wakes WFI", 3'b110);
    clr();

    // random phase against the model
    void'($urandom(32'h5EED_1234));
    for (int i = 0; i < RND_CYCLES; i++) begin
      wfiReq        = ($urandom % 100) < 4;
      wfeReq        = ($urandom % 100) < 6;
      irq           = ($urandom % 100) < 3;
      fiq           = ($urandom % 100) < 3;
      asyncAbort    = ($urandom % 100) < 2;
      maskI         = ($urandom % 2) == 0;
      maskF         = ($urandom % 2) == 0;
      maskA         = ($urandom % 2) == 0;
      dbgReq        = ($urandom % 100) < 2;
      dbgHalt       = ($urandom % 100) < 2;
      dbgInvasiveEn = ($urandom % 2) == 0;
      dbgPermit     = ($urandom % 2) == 0;
      eventIn       = ($urandom % 100) < 2;
      maintReq      = ($urandom % 100) < 2;
      cohReq        = ($urandom % 100) < 15;
      cohDone       = ($urandom % 100) < 30;
      sevCluster    = (($urandom % 100) < 3) ? NC'($urandom) : '0;
      step("R2..R10 random");
    end

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule